// File: doc/BRIEF.md
# Drift Time Hit Classifier

This block serves one drift cell of twelve sense wires. It works on the link clock, which runs six times faster than the crossing clock. A crossing marker restarts a tick counter, and the ticks then measure arrival time inside the capture window. For each wire, the first hit of the window is placed into a time bin. A hit that arrives after the last bin edge is discarded. The bin flags for all twelve wires are then packed into a narrow serial frame for a downstream pattern finder.

There are two classification modes. The short mode gives each wire two bins, early and late. The long mode gives each wire six bins. A short frame is one crossing long (six words) and a long frame is three crossings long (eighteen words). The bin edges are static configuration inputs and are counted in ticks. The mode is sampled at each accepted marker. While a frame is still on the link, a crossing marker has no effect. The window stays open until the marker that coincides with the last word of that frame.

Top module: `driftHitClassifier`

## Requirements
- R1: While reset is asserted, linkValid, frameStrobe and linkData are 0. The first crossing marker after reset opens a window but sends no frame.
- R2: Tick 0 is the cycle after an accepted marker, and the tick count rises by one each cycle after that. A hit at tick t goes to the lowest bin k whose edge satisfies t < edge[k]. Edge k is binEdges[5k+4:5k].
- R3: A hit at a tick at or beyond the last active edge sets no flag. The last active edge is edge[1] in short mode and edge[5] in long mode.
- R4: Only the earliest hit on a wire in a window sets a flag. Any later hit on that wire in the same window changes nothing.
- R5: Bin b of wire w is frame bit w*NB+b, where NB is 2 or 6. Word j on linkData carries frame bits 4j+3..4j, and words go out in increasing j.
- R6: A frame starts in the cycle after an accepted marker that closes an open window. frameStrobe is high for the first word only, and linkValid is high for 6 words (short) or 18 words (long).
- R7: A marker that arrives while a frame is being sent, other than on its last word, is ignored. It does not close the window, does not restart the tick count, does not sample the mode and does not raise frameStrobe.
- R8: binMode (0 = short, 1 = long) is sampled at an accepted marker. It sets the mode of the window that the marker opens and of that window's frame.
- R9: linkData is 0 whenever linkValid is 0.
- R10: The bin edges must increase strictly, so bin k covers ticks edge[k-1] to edge[k]-1 and bin 0 starts at tick 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous reset, active low |
| crossMark | input | 1 | One-cycle crossing marker |
| binMode | input | 1 | 0 = two bins, 1 = six bins |
| wireHit | input | 12 | Discriminated hit per wire, one bit each |
| binEdges | input | 30 | Six 5-bit bin edges in ticks; edge k at bits 5k+4:5k |
| linkData | output | 4 | Serial frame word |
| linkValid | output | 1 | High while frame words are on the link |
| frameStrobe | output | 1 | High on the first word of each frame |

## Verification
The assertions check framing on every cycle. frameStrobe must sit inside a frame and must follow a marker by one cycle. It must mark every rise of linkValid and is never high for two cycles in a row. The link must stay quiet between frames, and the edge configuration must increase at every marker. Only the bench scenarios can show the rest, because the assertions do not track each hit through to the frame: the bin each hit lands in, dropping late hits, keeping the earliest hit, the bit order of the packed frame, and the frame lengths. The same holds for ignoring markers mid-frame and for when a mode change takes effect.

// File: rtl/hcPkg.sv
package hcPkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic capEn;      // a window is open, hits may be captured
    logic clearCap;   // accepted marker: start a fresh window image
    logic loadFrame;  // closing window image goes to the shifter
    logic shiftWord;  // advance the shifter by one link word
    logic winMode;    // mode of the window currently open
  } hcStrobes_t;
endpackage

// File: rtl/hcControl.sv
module hcControl
  import hcPkg::*;
#(
  parameter int TW = 5,
  parameter int WORDS_SHORT = 6,
  parameter int WORDS_LONG = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          crossMark,
  input  logic          binMode,
  output hcStrobes_t    strb,
  output logic [TW-1:0] tick,
  output logic          linkValid,
  output logic          frameStrobe
);
  localparam int CW = $clog2(WORDS_LONG);

  logic          winOpen, winMode, txMode, busy, firstWord;
  logic [CW-1:0] wordCnt, lastWord;
  logic [TW-1:0] tickCnt;
  logic          accept, startTx;

  assign lastWord = txMode ? CW'(WORDS_LONG - 1) : CW'(WORDS_SHORT - 1);
  assign accept   = crossMark && (!busy || (wordCnt == lastWord));
  assign startTx  = accept && winOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOpen <= 1'b0;
      winMode <= 1'b0;
      tickCnt <= '0;
    end else if (accept) begin
      winOpen <= 1'b1;
      winMode <= binMode;
      tickCnt <= '0;
    end else if (tickCnt != {TW{1'b1}}) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      txMode    <= 1'b0;
      wordCnt   <= '0;
      firstWord <= 1'b0;
    end else if (startTx) begin
      busy      <= 1'b1;
      txMode    <= winMode;
      wordCnt   <= '0;
      firstWord <= 1'b1;
    end else begin
      firstWord <= 1'b0;
      if (busy) begin
        if (wordCnt == lastWord) busy <= 1'b0;
        else wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  assign strb.capEn     = winOpen;
  assign strb.clearCap  = accept;
  assign strb.loadFrame = startTx;
  assign strb.shiftWord = busy && !startTx;
  assign strb.winMode   = winMode;
  assign tick           = tickCnt;
  assign linkValid      = busy;
  assign frameStrobe    = firstWord;
endmodule

// File: rtl/hcDatapath.sv
module hcDatapath
  import hcPkg::*;
#(
  parameter int NWIRE = 12,
  parameter int NBMAX = 6,
  parameter int NBMIN = 2,
  parameter int TW = 5,
  parameter int LW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  hcStrobes_t          strb,
  input  logic [TW-1:0]       tick,
  input  logic [NWIRE-1:0]    wireHit,
  input  logic [NBMAX*TW-1:0] binEdges,
  output logic [LW-1:0]       linkData
);
  localparam int PB = NWIRE * NBMAX;
  localparam int SB = NWIRE * NBMIN;

  logic [TW-1:0] edgeVal [NBMAX];
  logic [NBMAX-1:0] binHit;
  logic [NWIRE-1:0][NBMAX-1:0] capReg, capNext;
  logic [PB-1:0] packLong, frameImg, shreg;
  logic [SB-1:0] packShort;

  // one-hot bin of the current tick; empty past the last active edge
  for (genvar k = 0; k < NBMAX; k++) begin : g_bin
    logic inUse, aboveLow;
    assign edgeVal[k] = binEdges[k*TW +: TW];
    assign inUse = (k < NBMIN) ? 1'b1 : strb.winMode;
    if (k == 0) begin : g_first
      assign aboveLow = 1'b1;
    end else begin : g_rest
      assign aboveLow = (tick >= edgeVal[k-1]);
    end
    assign binHit[k] = inUse && aboveLow && (tick < edgeVal[k]);
  end

  // a wire keeps its first flag; later hits leave it alone
  for (genvar w = 0; w < NWIRE; w++) begin : g_wire
    assign capNext[w] = (strb.capEn && wireHit[w] && (capReg[w] == '0)) ? binHit : capReg[w];
    for (genvar b = 0; b < NBMAX; b++) begin : g_long
      assign packLong[w*NBMAX + b] = capNext[w][b];
    end
    for (genvar b = 0; b < NBMIN; b++) begin : g_short
      assign packShort[w*NBMIN + b] = capNext[w][b];
    end
  end

  assign frameImg = strb.winMode ? packLong : {{(PB-SB){1'b0}}, packShort};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capReg <= '0;
    else if (strb.clearCap) capReg <= '0;
    else capReg <= capNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shreg <= '0;
    else if (strb.loadFrame) shreg <= frameImg;
    else if (strb.shiftWord) shreg <= shreg >> LW;
  end

  assign linkData = shreg[LW-1:0];
endmodule

// File: rtl/driftHitClassifier.sv
module driftHitClassifier
  import hcPkg::*;
#(
  parameter int NWIRE = 12,
  parameter int NBMAX = 6,
  parameter int NBMIN = 2,
  parameter int TW = 5,
  parameter int LW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                crossMark,
  input  logic                binMode,
  input  logic [NWIRE-1:0]    wireHit,
  input  logic [NBMAX*TW-1:0] binEdges,
  output logic [LW-1:0]       linkData,
  output logic                linkValid,
  output logic                frameStrobe
);
  localparam int WORDS_SHORT = NWIRE * NBMIN / LW;
  localparam int WORDS_LONG  = NWIRE * NBMAX / LW;

  hcStrobes_t    strb;
  logic [TW-1:0] tick;

  hcControl #(.TW(TW), .WORDS_SHORT(WORDS_SHORT), .WORDS_LONG(WORDS_LONG)) i_ctrl (
    .clk(clk), .rstN(rstN), .crossMark(crossMark), .binMode(binMode),
    .strb(strb), .tick(tick), .linkValid(linkValid), .frameStrobe(frameStrobe)
  );

  hcDatapath #(.NWIRE(NWIRE), .NBMAX(NBMAX), .NBMIN(NBMIN), .TW(TW), .LW(LW)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .tick(tick), .wireHit(wireHit),
    .binEdges(binEdges), .linkData(linkData)
  );
endmodule

// File: rtl/driftHitClassifier_chk.sv
module driftHitClassifier_chk #(
  parameter int NBMAX = 6,
  parameter int TW = 5,
  parameter int LW = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                crossMark,
  input logic [NBMAX*TW-1:0] binEdges,
  input logic [LW-1:0]       linkData,
  input logic                linkValid,
  input logic                frameStrobe
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkValid |-> (linkData == '0));

  // R6
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> linkValid);

  // R6
  strobe_after_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> $past(crossMark));

  // R6
  frame_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkValid) |-> frameStrobe);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

  for (genvar k = 1; k < NBMAX; k++) begin : g_edge
    // R10
    edge_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      crossMark |-> (binEdges[k*TW +: TW] > binEdges[(k-1)*TW +: TW]));
  end
endmodule

bind driftHitClassifier driftHitClassifier_chk #(.NBMAX(NBMAX), .TW(TW), .LW(LW)) i_chk (
  .clk(clk), .rstN(rstN), .crossMark(crossMark), .binEdges(binEdges),
  .linkData(linkData), .linkValid(linkValid), .frameStrobe(frameStrobe)
);

// File: tb/test_driftHitClassifier.sv
module test_driftHitClassifier;
  localparam logic [4:0] NO = 5'd31;
  localparam int EDGE [6] = '{2, 4, 7, 9, 12, 15};

  typedef struct packed {
    logic mode;
    logic mid;
    logic [11:0][4:0] hitA;
    logic [11:0][4:0] hitB;
  } vec_t;

  // hit ticks listed wire 11 first; NO = no hit
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, {5'd5,5'd4,5'd3,5'd2,5'd1,5'd0,5'd5,5'd4,5'd3,5'd2,5'd1,5'd0}, {12{NO}}},
    '{1'b0, 1'b0, {NO,NO,NO,NO,NO,NO,NO,NO,NO,5'd3,5'd2,5'd1},
                  {NO,NO,NO,NO,NO,NO,NO,NO,NO,NO,5'd0,5'd3}},
    '{1'b1, 1'b0, {5'd15,5'd14,5'd12,5'd9,5'd8,5'd7,5'd6,5'd4,5'd3,5'd2,5'd1,5'd0},
                  {5'd16,NO,NO,NO,NO,NO,NO,NO,NO,NO,NO,NO}},
    '{1'b1, 1'b1, {5'd6,5'd7,5'd8,5'd9,5'd10,5'd11,5'd12,5'd13,5'd14,5'd15,5'd16,5'd17},
                  {NO,NO,NO,NO,NO,NO,NO,NO,NO,NO,NO,5'd5}},
    '{1'b0, 1'b1, {12{5'd1}}, {12{5'd3}}},
    '{1'b0, 1'b0, {5'd1,5'd2,5'd3,5'd4,5'd5,5'd0,5'd1,5'd2,5'd3,5'd4,5'd5,5'd0}, {12{NO}}},
    '{1'b1, 1'b0, {5'd9,5'd2,5'd12,5'd5,5'd15,5'd8,5'd1,5'd11,5'd4,5'd14,5'd7,5'd0},
                  {5'd0,5'd8,5'd5,5'd2,5'd10,5'd7,5'd4,5'd1,5'd9,5'd6,5'd3,5'd0}},
    '{1'b0, 1'b0, {12{NO}}, {12{NO}}}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        crossMark = 1'b0;
  logic        binMode = 1'b0;
  logic [11:0] wireHit = '0;
  logic [29:0] binEdges;
  logic [3:0]  linkData;
  logic        linkValid, frameStrobe;

  int checks = 0;
  int errors = 0;

  logic [71:0] expBits [16];
  int          expLen [16];
  int          wrP = 0;
  int          rdP = 0;
  logic [71:0] rxBits;
  int          rxCnt = 0;
  logic        inFrame = 1'b0;

  always #5 clk = ~clk;

  assign binEdges = {5'(EDGE[5]), 5'(EDGE[4]), 5'(EDGE[3]), 5'(EDGE[2]), 5'(EDGE[1]), 5'(EDGE[0])};

  driftHitClassifier i_driftHitClassifier (
    .clk(clk), .rstN(rstN), .crossMark(crossMark), .binMode(binMode),
    .wireHit(wireHit), .binEdges(binEdges), .linkData(linkData),
    .linkValid(linkValid), .frameStrobe(frameStrobe)
  );

  task automatic check(input logic ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] modelFrame(input vec_t v);
    logic [71:0] r;
    int nb;
    r = '0;
    nb = v.mode ? 6 : 2;
    for (int w = 0; w < 12; w++) begin
      int tm;
      logic found;
      tm = (v.hitA[w] < v.hitB[w]) ? int'(v.hitA[w]) : int'(v.hitB[w]);
      found = 1'b0;
      if (tm != 31) begin
        for (int k = 0; k < nb; k++) begin
          if (!found && tm < EDGE[k]) begin
            r[w*nb + k] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end
    return r;
  endfunction

  task automatic pushExp(input logic [71:0] bits, input int len);
    expBits[wrP % 16] = bits;
    expLen[wrP % 16] = len;
    wrP++;
  endtask

  task automatic finalizeFrame();
    if (wrP == rdP) begin
      check(1'b0, "R1 R7 unexpected frame", 72'(rxCnt), 72'd0);
    end else begin
      check(rxCnt == expLen[rdP % 16], "R6 frame length", 72'(rxCnt), 72'(expLen[rdP % 16]));
      check(rxBits == expBits[rdP % 16], "R2 R3 R4 R5 R10 frame bits", rxBits, expBits[rdP % 16]);
      rdP++;
    end
    inFrame = 1'b0;
  endtask

  // link monitor, samples half a cycle away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      inFrame = 1'b0;
    end else begin
      if (frameStrobe) begin
        if (inFrame) finalizeFrame();
        inFrame = 1'b1;
        rxCnt = 0;
        rxBits = '0;
      end
      if (linkValid) begin
        if (!inFrame) begin
          check(1'b0, "R6 words without strobe", 72'(linkData), 72'd0);
        end else begin
          if (rxCnt < 18) rxBits[rxCnt*4 +: 4] = linkData;
          rxCnt++;
        end
      end else begin
        check(linkData == 4'd0, "R9 idle link data", 72'(linkData), 72'd0);
        if (inFrame) finalizeFrame();
      end
    end
  end

  task automatic runWindow(input int idx, input logic nextMode, input int prevLen);
    vec_t v;
    int curLen, len;
    v = VECS[idx];
    curLen = v.mode ? 18 : 6;
    len = (curLen > prevLen) ? curLen : prevLen;
    for (int t = 0; t < len; t++) begin
      logic midTick;
      for (int w = 0; w < 12; w++) wireHit[w] = (int'(v.hitA[w]) == t) || (int'(v.hitB[w]) == t);
      midTick = v.mid && (t == 5 || t == 11);
      if (midTick) begin
        crossMark = 1'b1;
        binMode = ~v.mode;
      end else if (t == len - 1) begin
        crossMark = 1'b1;
        binMode = nextMode;
        pushExp(modelFrame(v), curLen);
      end else begin
        crossMark = 1'b0;
      end
      @(negedge clk);
      if (midTick) check(frameStrobe == 1'b0, "R7 mid-frame marker ignored", 72'(frameStrobe), 72'd0);
    end
    crossMark = 1'b0;
    wireHit = '0;
    check(frameStrobe == 1'b1, "R6 R8 strobe after closing marker", 72'(frameStrobe), 72'd1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int prevLen;
    repeat (3) @(negedge clk);
    #1;
    check(linkValid == 1'b0, "R1 reset linkValid", 72'(linkValid), 72'd0);
    check(frameStrobe == 1'b0, "R1 reset frameStrobe", 72'(frameStrobe), 72'd0);
    check(linkData == 4'd0, "R1 reset linkData", 72'(linkData), 72'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // first marker only opens a window
    crossMark = 1'b1;
    binMode = VECS[0].mode;
    @(negedge clk);
    crossMark = 1'b0;
    check(frameStrobe == 1'b0, "R1 first marker sends no frame", 72'(frameStrobe), 72'd0);

    prevLen = 0;
    for (int i = 0; i < 8; i++) begin
      logic nm;
      nm = (i < 7) ? VECS[i+1].mode : 1'b0;
      runWindow(i, nm, prevLen);
      prevLen = VECS[i].mode ? 18 : 6;
    end
    repeat (24) @(negedge clk);
    check(wrP == rdP, "R6 all frames received", 72'(rdP), 72'(wrP));

    // reset in the middle of a frame
    repeat (5) @(negedge clk);
    crossMark = 1'b1;
    @(negedge clk);
    crossMark = 1'b0;
    repeat (2) @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    check(linkValid == 1'b0, "R1 reset mid-frame linkValid", 72'(linkValid), 72'd0);
    check(linkData == 4'd0, "R1 reset mid-frame linkData", 72'(linkData), 72'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    crossMark = 1'b1;
    binMode = 1'b0;
    @(negedge clk);
    crossMark = 1'b0;
    check(frameStrobe == 1'b0, "R1 no frame after reset marker", 72'(frameStrobe), 72'd0);
    check(linkValid == 1'b0, "R1 link idle after reset marker", 72'(linkValid), 72'd0);

    // short window: wire 3 prompt (tick 0), wire 7 late (tick 3), wire 9 dropped (tick 4)
    for (int t = 0; t < 6; t++) begin
      wireHit = '0;
      if (t == 0) wireHit[3] = 1'b1;
      if (t == 3) wireHit[7] = 1'b1;
      if (t == 4) wireHit[9] = 1'b1;
      if (t == 5) begin
        crossMark = 1'b1;
        pushExp(72'(1) << 6 | 72'(1) << 15, 6);
      end
      @(negedge clk);
    end
    crossMark = 1'b0;
    wireHit = '0;
    check(frameStrobe == 1'b1, "R2 R3 R6 frame after reopened window", 72'(frameStrobe), 72'd1);
    repeat (12) @(negedge clk);
    check(wrP == rdP, "R6 final frame received", 72'(rdP), 72'(wrP));

    summary();
    $finish;
  end
endmodule